// File: doc/BRIEF.md
# Three-Stage Interrupt Priority Arbiter

This block collects interrupt requests from a set of event inputs. It picks one of them and hands it to the CPU side as a one-cycle inject pulse. The pulse carries the winner's source index, interrupt level and group level.

Each event input passes through a synchroniser, and a rising edge sets that source's request flag. Each source has a control entry that holds an enable bit, a 4-bit interrupt level and a 2-bit group level, written through a small configuration port.

Arbitration runs as a round of three clocked stages:

- Stage one picks the best eligible pending source.
- Stage two weighs that candidate against a debug-service request, which carries its own level.
- Stage three accepts the result only if interrupts are globally enabled and the candidate's level is above the CPU's current task level. A debug request skips this check.

If a round does not accept, a fresh round starts. A request that arrives while a round is running waits for the next round, so latency grows by up to one round.

On acceptance the winner's flag is cleared and the inject pulse is issued. A fixed trap-preparation delay then runs, after which an entry strobe marks the point where the CPU fetches the handler. The arbiter stays busy until the CPU acknowledges.

Top module: `irq_arbiter_top`

## Requirements
- R1: A rising edge on `evt_i[k]` that is first sampled at clock edge E sets `req_flag_o[k]` at edge E+2. An input held high does not set the flag again.
- R2: A source whose enable bit is 0 or whose level is 0 is never injected, and its request flag stays set.
- R3: Among eligible pending sources (flag set, enabled, level not 0), the one with the highest interrupt level is injected first.
- R4: At equal interrupt level the higher group level wins. At equal level and group the lowest source index wins.
- R5: A debug request wins stage two when no interrupt candidate exists or when `dbg_lvl_i` is greater than or equal to the candidate's level. A debug winner is accepted whatever `ien_i` and `cpu_lvl_i` are. It is injected with `inject_dbg_o`=1, index 0, group 0 and level `dbg_lvl_i`, and it clears no request flag.
- R6: An interrupt is accepted only when its level is strictly greater than `cpu_lvl_i`.
- R7: An interrupt is accepted only when `ien_i` is 1.
- R8: `inject_o` is high for exactly one cycle. In that same cycle the index, level and group fields are valid and the winner's request flag already reads 0.
- R9: `entry_o` pulses for one cycle exactly TRAP_CYC (default 5) cycles after `inject_o`.
- R10: `busy_o` goes high with `inject_o` and stays high until `ack_i` is sampled high after `entry_o`. No inject occurs while the arbiter is busy.
- R11: When the arbiter is idle, the inject pulse appears 3 cycles after a new request flag becomes visible.
- R12: After reset all flags, control entries and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | N_SRC | Event inputs, rising edge sets the request flag |
| cfg_we_i | input | 1 | Write strobe for a source control entry |
| cfg_sel_i | input | IDX_W | Source index written |
| cfg_en_i | input | 1 | Enable bit to write |
| cfg_lvl_i | input | LVL_W | Interrupt level to write |
| cfg_grp_i | input | GRP_W | Group level to write |
| dbg_req_i | input | 1 | Pending debug-service request |
| dbg_lvl_i | input | LVL_W | Level of the debug request |
| cpu_lvl_i | input | LVL_W | CPU current task level |
| ien_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU acknowledge, releases busy |
| req_flag_o | output | N_SRC | Request flags |
| inject_o | output | 1 | One-cycle inject pulse |
| inject_dbg_o | output | 1 | Injected request is the debug service |
| inject_idx_o | output | IDX_W | Injected source index |
| inject_lvl_o | output | LVL_W | Injected level |
| inject_grp_o | output | GRP_W | Injected group level |
| entry_o | output | 1 | Handler entry strobe |
| busy_o | output | 1 | Arbiter waiting for acknowledge |

## Verification
The assertions assume the CPU raises `ack_i` only after the entry strobe. They also assume the debug source holds `dbg_req_i` until the acknowledge, because the inject fields are only checked under that handshake.

The flag-clear property allows for a new event edge that lands on the acceptance edge, where the set wins. The stimulus avoids that coincidence by dropping every event input before the sources it feeds are served.

The stimulus changes `ien_i` and `cpu_lvl_i` only after all pending flags have been stable for longer than one round. Because of that, a candidate captured in stage one always reflects the final set of requests.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [2:0] {
    RND_IDLE,
    RND_DBG,
    RND_CPU,
    RND_PREP,
    RND_HOLD
  } rnd_state_e;
endpackage

// File: rtl/irq_evt_sync.sv
module irq_evt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q  <= '0;
      last_d_q <= 1'b0;
    end else begin
      chain_q  <= (chain_q << 1) | SYNC_STAGES'(evt_i);
      last_d_q <= chain_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~last_d_q;
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int GRP_W = 2,
  parameter int IDX_W = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_SRC-1:0]                set_i,
  input  logic [N_SRC-1:0]                clr_i,
  input  logic                            cfg_we_i,
  input  logic [IDX_W-1:0]                cfg_sel_i,
  input  logic                            cfg_en_i,
  input  logic [LVL_W-1:0]                cfg_lvl_i,
  input  logic [GRP_W-1:0]                cfg_grp_i,
  output logic [N_SRC-1:0]                flag_o,
  output logic [N_SRC-1:0]                en_o,
  output logic [N_SRC-1:0][LVL_W-1:0]     lvl_o,
  output logic [N_SRC-1:0][GRP_W-1:0]     grp_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic hit;
    assign hit = cfg_we_i && (cfg_sel_i == IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[k] <= 1'b0;
        en_o[k]   <= 1'b0;
        lvl_o[k]  <= '0;
        grp_o[k]  <= '0;
      end else begin
        // new event wins over a same-cycle acceptance clear
        if (set_i[k])      flag_o[k] <= 1'b1;
        else if (clr_i[k]) flag_o[k] <= 1'b0;
        if (hit) begin
          en_o[k]  <= cfg_en_i;
          lvl_o[k] <= cfg_lvl_i;
          grp_o[k] <= cfg_grp_i;
        end
      end
    end
  end
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int GRP_W = 2,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [N_SRC-1:0][GRP_W-1:0] grp_i,
  output logic                        win_valid_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic [LVL_W-1:0]            win_lvl_o,
  output logic [GRP_W-1:0]            win_grp_o
);
  localparam int KEY_W = LVL_W + GRP_W;

  logic [KEY_W-1:0] best_key;

  // ascending scan, strict compare keeps the lowest index on a full tie
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best_key    = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (elig_i[k] && ({lvl_i[k], grp_i[k]} > best_key)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(k);
        best_key    = {lvl_i[k], grp_i[k]};
      end
    end
    win_lvl_o = best_key[KEY_W-1:GRP_W];
    win_grp_o = best_key[GRP_W-1:0];
  end
endmodule

// File: rtl/irq_round_ctrl.sv
module irq_round_ctrl
  import irq_arb_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int GRP_W    = 2,
  parameter int IDX_W    = 3,
  parameter int TRAP_CYC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tree_valid_i,
  input  logic [IDX_W-1:0] tree_idx_i,
  input  logic [LVL_W-1:0] tree_lvl_i,
  input  logic [GRP_W-1:0] tree_grp_i,
  input  logic             cand_live_i,
  input  logic             dbg_req_i,
  input  logic [LVL_W-1:0] dbg_lvl_i,
  input  logic [LVL_W-1:0] cpu_lvl_i,
  input  logic             ien_i,
  input  logic             ack_i,
  output logic [IDX_W-1:0] cand_idx_o,
  output logic             accept_irq_o,
  output logic             inject_o,
  output logic             inject_dbg_o,
  output logic [IDX_W-1:0] inject_idx_o,
  output logic [LVL_W-1:0] inject_lvl_o,
  output logic [GRP_W-1:0] inject_grp_o,
  output logic             entry_o,
  output logic             busy_o
);
  localparam int CNT_W = (TRAP_CYC > 1) ? $clog2(TRAP_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRAP_CYC - 1);

  rnd_state_e       st_q;
  logic             c_valid_q, c_dbg_q;
  logic [IDX_W-1:0] c_idx_q;
  logic [LVL_W-1:0] c_lvl_q;
  logic [GRP_W-1:0] c_grp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             dbg_wins;

  assign dbg_wins     = dbg_req_i && (!c_valid_q || (dbg_lvl_i >= c_lvl_q));
  assign accept       = (st_q == RND_CPU) && c_valid_q &&
                        (c_dbg_q || (ien_i && (c_lvl_q > cpu_lvl_i) && cand_live_i));
  assign accept_irq_o = accept && !c_dbg_q;
  assign cand_idx_o   = c_idx_q;
  assign busy_o       = (st_q == RND_PREP) || (st_q == RND_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= RND_IDLE;
      c_valid_q    <= 1'b0;
      c_dbg_q      <= 1'b0;
      c_idx_q      <= '0;
      c_lvl_q      <= '0;
      c_grp_q      <= '0;
      cnt_q        <= '0;
      inject_o     <= 1'b0;
      inject_dbg_o <= 1'b0;
      inject_idx_o <= '0;
      inject_lvl_o <= '0;
      inject_grp_o <= '0;
      entry_o      <= 1'b0;
    end else begin
      inject_o <= 1'b0;
      entry_o  <= 1'b0;
      unique case (st_q)
        RND_IDLE: begin
          // stage one: latch best source
          if (tree_valid_i || dbg_req_i) begin
            c_valid_q <= tree_valid_i;
            c_dbg_q   <= 1'b0;
            c_idx_q   <= tree_idx_i;
            c_lvl_q   <= tree_lvl_i;
            c_grp_q   <= tree_grp_i;
            st_q      <= RND_DBG;
          end
        end
        RND_DBG: begin
          // stage two: debug service takes ties
          if (dbg_wins) begin
            c_valid_q <= 1'b1;
            c_dbg_q   <= 1'b1;
            c_idx_q   <= '0;
            c_lvl_q   <= dbg_lvl_i;
            c_grp_q   <= '0;
          end
          st_q <= RND_CPU;
        end
        RND_CPU: begin
          // stage three: CPU level and global enable
          if (accept) begin
            inject_o     <= 1'b1;
            inject_dbg_o <= c_dbg_q;
            inject_idx_o <= c_idx_q;
            inject_lvl_o <= c_lvl_q;
            inject_grp_o <= c_grp_q;
            cnt_q        <= '0;
            st_q         <= RND_PREP;
          end else begin
            st_q <= RND_IDLE;
          end
        end
        RND_PREP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            entry_o <= 1'b1;
            st_q    <= RND_HOLD;
          end
        end
        RND_HOLD: begin
          if (ack_i) st_q <= RND_IDLE;
        end
        default: st_q <= RND_IDLE;
      endcase
    end
  end

  AST_INJECT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> !inject_o); // R8
  AST_INJECT_ABOVE_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && !inject_dbg_o) |-> (inject_lvl_o > $past(cpu_lvl_i))); // R6
  AST_INJECT_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && !inject_dbg_o) |-> $past(ien_i)); // R7
  AST_NO_INJECT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> !inject_o); // R10
  AST_BUSY_HELD_TO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ack_i)); // R10
  AST_INJECT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |-> busy_o); // R10
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top #(
  parameter int N_SRC       = 8,
  parameter int LVL_W       = 4,
  parameter int GRP_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TRAP_CYC    = 5,
  localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_sel_i,
  input  logic             cfg_en_i,
  input  logic [LVL_W-1:0] cfg_lvl_i,
  input  logic [GRP_W-1:0] cfg_grp_i,
  input  logic             dbg_req_i,
  input  logic [LVL_W-1:0] dbg_lvl_i,
  input  logic [LVL_W-1:0] cpu_lvl_i,
  input  logic             ien_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] req_flag_o,
  output logic             inject_o,
  output logic             inject_dbg_o,
  output logic [IDX_W-1:0] inject_idx_o,
  output logic [LVL_W-1:0] inject_lvl_o,
  output logic [GRP_W-1:0] inject_grp_o,
  output logic             entry_o,
  output logic             busy_o
);
  logic [N_SRC-1:0]            rise_vec, clr_vec, en_vec, elig_vec;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_vec;
  logic [N_SRC-1:0][GRP_W-1:0] grp_vec;
  logic                        win_valid;
  logic [IDX_W-1:0]            win_idx, cand_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic [GRP_W-1:0]            win_grp;
  logic                        accept_irq;

  for (genvar k = 0; k < N_SRC; k++) begin : g_evt
    irq_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[k]),
      .rise_o (rise_vec[k])
    );
    assign elig_vec[k] = req_flag_o[k] && en_vec[k] && (lvl_vec[k] != '0);
    assign clr_vec[k]  = accept_irq && (cand_idx == IDX_W'(k));

    AST_WINNER_IS_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_valid && elig_vec[k]) |-> ({lvl_vec[k], grp_vec[k]} <= {win_lvl, win_grp})); // R3
  end

  irq_src_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (rise_vec),
    .clr_i     (clr_vec),
    .cfg_we_i  (cfg_we_i),
    .cfg_sel_i (cfg_sel_i),
    .cfg_en_i  (cfg_en_i),
    .cfg_lvl_i (cfg_lvl_i),
    .cfg_grp_i (cfg_grp_i),
    .flag_o    (req_flag_o),
    .en_o      (en_vec),
    .lvl_o     (lvl_vec),
    .grp_o     (grp_vec)
  );

  irq_arb_tree #(.N_SRC(N_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_tree (
    .elig_i      (elig_vec),
    .lvl_i       (lvl_vec),
    .grp_i       (grp_vec),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl),
    .win_grp_o   (win_grp)
  );

  irq_round_ctrl #(.LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .TRAP_CYC(TRAP_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tree_valid_i (win_valid),
    .tree_idx_i   (win_idx),
    .tree_lvl_i   (win_lvl),
    .tree_grp_i   (win_grp),
    .cand_live_i  (elig_vec[cand_idx]),
    .dbg_req_i    (dbg_req_i),
    .dbg_lvl_i    (dbg_lvl_i),
    .cpu_lvl_i    (cpu_lvl_i),
    .ien_i        (ien_i),
    .ack_i        (ack_i),
    .cand_idx_o   (cand_idx),
    .accept_irq_o (accept_irq),
    .inject_o     (inject_o),
    .inject_dbg_o (inject_dbg_o),
    .inject_idx_o (inject_idx_o),
    .inject_lvl_o (inject_lvl_o),
    .inject_grp_o (inject_grp_o),
    .entry_o      (entry_o),
    .busy_o       (busy_o)
  );

  AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && !inject_dbg_o && !$past(|rise_vec)) |-> !req_flag_o[inject_idx_o]); // R8
  AST_LEVEL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && !inject_dbg_o) |-> (inject_lvl_o != '0)); // R2
endmodule

// File: tb/irq_arbiter_top_tb.sv
module irq_arbiter_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic       cfg_en = 1'b0;
  logic [3:0] cfg_lvl = '0;
  logic [1:0] cfg_grp = '0;
  logic       dbg_req = 1'b0;
  logic [3:0] dbg_lvl = '0;
  logic [3:0] cpu_lvl = '0;
  logic       ien = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] req_flag;
  logic       inject_o, inject_dbg, entry, busy;
  logic [2:0] inject_idx;
  logic [3:0] inject_lvl;
  logic [1:0] inject_grp;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  bit m_flag[8];
  bit m_en[8];
  int m_lvl[8];
  int m_grp[8];

  always #10 clk = ~clk;

  irq_arbiter_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_en_i(cfg_en),
    .cfg_lvl_i(cfg_lvl), .cfg_grp_i(cfg_grp),
    .dbg_req_i(dbg_req), .dbg_lvl_i(dbg_lvl), .cpu_lvl_i(cpu_lvl),
    .ien_i(ien), .ack_i(ack),
    .req_flag_o(req_flag), .inject_o(inject_o), .inject_dbg_o(inject_dbg),
    .inject_idx_o(inject_idx), .inject_lvl_o(inject_lvl), .inject_grp_o(inject_grp),
    .entry_o(entry), .busy_o(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_pick();
    int best = -1;
    int bkey = 0;
    for (int k = 0; k < 8; k++) begin
      if (m_flag[k] && m_en[k] && m_lvl[k] != 0 && (m_lvl[k] * 4 + m_grp[k]) > bkey) begin
        best = k;
        bkey = m_lvl[k] * 4 + m_grp[k];
      end
    end
    return best;
  endfunction

  task automatic cfg_wr(input int idx, input bit en, input int lvl, input int grp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_en = en; cfg_lvl = 4'(lvl); cfg_grp = 2'(grp);
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[idx] = en; m_lvl[idx] = lvl; m_grp[idx] = grp;
  endtask

  task automatic fire(input logic [7:0] mask);
    @(negedge clk);
    evt = mask;
    repeat (2) @(negedge clk);
    evt = '0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) if (mask[k]) m_flag[k] = 1'b1;
  endtask

  task automatic wait_inj(input int max, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (inject_o) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (inject_o) bad = 1'b1;
    end
    chk(!bad, tag, int'(bad), 0);
  endtask

  // called on the negedge where inject_o is first seen
  task automatic serve(input int e_idx, input int e_lvl, input int e_grp, input bit e_dbg,
                       input string tag);
    int n = 0;
    chk(inject_dbg == e_dbg, {tag, " dbg"}, int'(inject_dbg), int'(e_dbg));
    chk(int'(inject_idx) == e_idx, {tag, " idx"}, int'(inject_idx), e_idx);
    chk(int'(inject_lvl) == e_lvl, {tag, " lvl"}, int'(inject_lvl), e_lvl);
    chk(int'(inject_grp) == e_grp, {tag, " grp"}, int'(inject_grp), e_grp);
    if (!e_dbg) begin
      chk(req_flag[e_idx] == 1'b0, "R8 flag cleared with inject", int'(req_flag[e_idx]), 0);
      m_flag[e_idx] = 1'b0;
    end
    @(negedge clk);
    chk(!inject_o, "R8 inject one cycle", int'(inject_o), 0);
    n = 1;
    while (!entry && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(n == 5, "R9 entry delay", n, 5);
    chk(busy, "R10 busy at entry", int'(busy), 1);
    @(negedge clk);
    chk(busy, "R10 busy held without ack", int'(busy), 1);
    ack = 1'b1;
    dbg_req = 1'b0;
    @(negedge clk);
    ack = 1'b0;
    chk(!busy, "R10 busy released by ack", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk(req_flag == '0, "R12 flags at reset", int'(req_flag), 0);
    chk(!inject_o && !entry && !busy, "R12 outputs at reset",
        int'({inject_o, entry, busy}), 0);
  endtask

  task automatic t_sync();
    ien = 1'b0;
    cfg_wr(0, 1'b1, 4, 3);
    @(negedge clk);
    evt[0] = 1'b1;
    @(negedge clk);
    chk(!req_flag[0], "R1 flag low after first edge", int'(req_flag[0]), 0);
    @(negedge clk);
    chk(!req_flag[0], "R1 flag low after second edge", int'(req_flag[0]), 0);
    @(negedge clk);
    chk(req_flag[0], "R1 flag set after third edge", int'(req_flag[0]), 1);
    m_flag[0] = 1'b1;
    repeat (3) @(negedge clk);
    evt[0] = 1'b0;
  endtask

  task automatic t_batch();
    bit seen;
    int exp;
    cfg_wr(1, 1'b1, 9, 0);
    cfg_wr(2, 1'b1, 9, 2);
    cfg_wr(3, 1'b1, 9, 2);
    cfg_wr(4, 1'b1, 0, 3);
    cfg_wr(5, 1'b0, 15, 3);
    cfg_wr(6, 1'b1, 12, 1);
    cfg_wr(7, 1'b1, 9, 1);
    fire(8'hFE);
    repeat (6) @(negedge clk);
    cpu_lvl = '0;
    ien = 1'b1;
    exp = model_pick();
    while (exp >= 0) begin
      wait_inj(30, seen);
      chk(seen, "R3 pending source injected", int'(seen), 1);
      if (!seen) break;
      serve(exp, m_lvl[exp], m_grp[exp], 1'b0, "R3 R4 priority order");
      exp = model_pick();
    end
    quiet(15, "R2 ineligible sources not injected");
    chk(req_flag[4] && req_flag[5], "R2 ineligible flags kept",
        int'({req_flag[5], req_flag[4]}), 3);
  endtask

  task automatic t_latency();
    int n = 0;
    bit seen;
    @(negedge clk);
    evt[1] = 1'b1;
    while (!req_flag[1] && n < 10) begin
      @(negedge clk);
      n++;
    end
    m_flag[1] = 1'b1;
    n = 0;
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n++;
      if (inject_o) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen && n == 3, "R11 idle latency", n, 3);
    evt[1] = 1'b0;
    if (seen) serve(1, 9, 0, 1'b0, "R11 injected source");
  endtask

  task automatic t_cpu_mask();
    bit seen;
    cpu_lvl = 4'd9;
    fire(8'h04);
    quiet(15, "R6 level equal to CPU masked");
    chk(req_flag[2], "R6 masked flag kept", int'(req_flag[2]), 1);
    cpu_lvl = 4'd8;
    wait_inj(20, seen);
    chk(seen, "R6 accepted above CPU level", int'(seen), 1);
    if (seen) serve(2, 9, 2, 1'b0, "R6 unmasked source");
    cpu_lvl = '0;
  endtask

  task automatic t_ien();
    bit seen;
    ien = 1'b0;
    fire(8'h08);
    quiet(15, "R7 global enable off masks");
    chk(req_flag[3], "R7 masked flag kept", int'(req_flag[3]), 1);
    ien = 1'b1;
    wait_inj(20, seen);
    chk(seen, "R7 accepted after enable", int'(seen), 1);
    if (seen) serve(3, 9, 2, 1'b0, "R7 source");
  endtask

  task automatic t_dbg();
    bit seen;
    ien = 1'b0;
    fire(8'h80);
    repeat (4) @(negedge clk);
    dbg_req = 1'b1;
    dbg_lvl = 4'd9;
    wait_inj(20, seen);
    chk(seen, "R5 debug wins tie without enable", int'(seen), 1);
    if (seen) serve(0, 9, 0, 1'b1, "R5 debug inject");
    chk(req_flag[7], "R5 debug leaves flag", int'(req_flag[7]), 1);
    @(negedge clk);
    dbg_req = 1'b1;
    dbg_lvl = 4'd8;
    quiet(15, "R5 lower debug loses stage two");
    dbg_req = 1'b0;
    @(negedge clk);
    ien = 1'b1;
    wait_inj(20, seen);
    chk(seen, "R5 interrupt after debug", int'(seen), 1);
    if (seen) serve(7, 9, 1, 1'b0, "R5 interrupt source");
    ien = 1'b0;
    @(negedge clk);
    dbg_req = 1'b1;
    dbg_lvl = 4'd3;
    wait_inj(20, seen);
    chk(seen, "R5 debug alone", int'(seen), 1);
    if (seen) serve(0, 3, 0, 1'b1, "R5 debug alone inject");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      m_flag[k] = 0; m_en[k] = 0; m_lvl[k] = 0; m_grp[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync();
    t_batch();
    t_latency();
    t_cpu_mask();
    t_ien();
    t_dbg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule